// File: doc/BRIEF.md
# Victim Buffer Offset Table Controller

This block keeps the tag side of a victim buffer held in DRAM. The buffer takes dirty lines that the cache hierarchy evicts before their transaction has committed. Each eviction request carries a physical byte address, a transaction ID and a data handle. The low line-address bits pick one table entry. That entry holds eight tagged fields, and each field records a 48-bit line address, a 15-bit transaction ID and a valid flag. The block compares all eight fields with the request's address. On a hit it reuses the matching field. On a miss it allocates a field, displacing an occupant when none is free.

The buffer slot of a line is never stored. It is the entry index followed by the field index. When a line is displaced, the block asks for an NVM write-back if the line's transaction has committed, and for an abort of that transaction if it has not. Commit status is looked up combinationally through one query lane per field. Every change of line ownership sends increment and decrement events to the transaction table.

Requests and responses use valid/ready. `req_ready` is high only while the block is idle. Once `rsp_valid` rises, the response stays unchanged until the consumer takes it with `rsp_ready`. No new request is accepted until then. The transaction table must answer `cq_done` in the same cycle it sees `cq_txn`.

Top module: `vb_tag_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, both event valids are 0, and every field of every entry is invalid.
- R2: The entry index is `req_paddr[6+IDX_W-1:6]`, with IDX_W = log2(ENTRIES). The stored line address is `req_paddr[53:6]`. `rsp_slot` equals entry index × WAYS + field index.
- R3: A request whose line address equals a valid field of its entry gives `rsp_hit`=1 and that field's slot, and displaces nothing.
- R4: A miss takes the lowest-index invalid field if one exists. It gives `rsp_hit`=0 and an increment event for the request's transaction, with no decrement, write-back or abort.
- R5: A miss on a full entry with at least one field whose transaction is committed (`cq_done`=1) displaces the lowest such field. It raises `rsp_wb` with that field's line and transaction on `rsp_victim_line` and `rsp_victim_txn`, a decrement for the victim and an increment for the request.
- R6: A miss on a full entry whose fields are all uncommitted displaces field 0. It raises `rsp_abort` with the victim's transaction on `rsp_victim_txn`, a decrement for the victim and an increment for the request.
- R7: While a response is pending, `req_ready` is 0 and `rsp_valid`, `rsp_hit`, `rsp_slot` and `rsp_handle` hold steady until `rsp_ready` is 1. `rsp_handle` echoes `req_handle`.
- R8: A hit by a different transaction moves ownership: a decrement for the old transaction and an increment for the new one. A hit by the same transaction emits no event.
- R9: `rsp_valid` rises on the second clock edge after acceptance. Events are valid only in that first response cycle.
- R10: `rsp_wb` and `rsp_abort` are never both set, and neither is set on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Eviction request valid |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_paddr | input | LINE_W+6 | Physical byte address of the evicted line |
| req_txn | input | TXN_W | Owning transaction ID |
| req_handle | input | HANDLE_W | Data handle, echoed on the response |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_hit | output | 1 | Line already present |
| rsp_slot | output | log2(ENTRIES)+log2(WAYS) | Buffer slot {entry, field} |
| rsp_handle | output | HANDLE_W | Echoed handle |
| rsp_wb | output | 1 | Displaced committed line needs NVM write-back |
| rsp_abort | output | 1 | Displaced line's transaction must abort |
| rsp_victim_line | output | LINE_W | Displaced line address |
| rsp_victim_txn | output | TXN_W | Displaced line's transaction |
| cq_txn | output | WAYS*TXN_W | Transaction ID of each field of the looked-up entry |
| cq_done | input | WAYS | Committed flag per lane of `cq_txn` |
| ev_inc_valid | output | 1 | Line count increment event |
| ev_inc_txn | output | TXN_W | Transaction to increment |
| ev_dec_valid | output | 1 | Line count decrement event |
| ev_dec_txn | output | TXN_W | Transaction to decrement |

## Verification
A stale or corrupted field in the table shows up on the next request that maps to its entry. The symptoms are a hit reported as a miss (or the reverse), a slot off by a field, or a displaced line with the wrong address or transaction. A wrong choice of victim kind shows up as a write-back where an abort was due, or the reverse. All of these appear in the first response cycle, two edges after acceptance. A fault in the event logic shows up as an event in a later cycle or a missing decrement. The bench keeps a shadow of every entry and a commit map, so each response is compared field by field against that model.

// File: rtl/vb_pkg.sv
package vb_pkg;
  localparam int LINE_OFF = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_RESP = 2'd2
  } vb_state_e;

  typedef enum logic [1:0] {
    KIND_FREE = 2'd0,
    KIND_DONE = 2'd1,
    KIND_LIVE = 2'd2
  } vb_kind_e;
endpackage

// File: rtl/vb_entry_store.sv
module vb_entry_store #(
  parameter int LINE_W  = 48,
  parameter int TXN_W   = 15,
  parameter int WAYS    = 8,
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [WAYS-1:0]            rd_valid,
  output logic [WAYS*LINE_W-1:0]     rd_line,
  output logic [WAYS*TXN_W-1:0]      rd_txn,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [$clog2(WAYS)-1:0]    wr_way,
  input  logic [LINE_W-1:0]          wr_line,
  input  logic [TXN_W-1:0]           wr_txn
);
  logic [LINE_W-1:0] line_q [ENTRIES][WAYS];
  logic [TXN_W-1:0]  txn_q  [ENTRIES][WAYS];
  logic [WAYS-1:0]   vld_q  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) vld_q[e] <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_q[wr_idx][wr_way] <= wr_line;
      txn_q[wr_idx][wr_way]  <= wr_txn;
    end
  end

  assign rd_valid = vld_q[rd_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_line[w*LINE_W +: LINE_W] = line_q[rd_idx][w];
    assign rd_txn[w*TXN_W +: TXN_W]    = txn_q[rd_idx][w];
  end
endmodule

// File: rtl/vb_way_match.sv
module vb_way_match #(
  parameter int LINE_W = 48,
  parameter int WAYS   = 8
) (
  input  logic [WAYS-1:0]         valid,
  input  logic [WAYS*LINE_W-1:0]  lines,
  input  logic [LINE_W-1:0]       key,
  output logic                    hit,
  output logic [$clog2(WAYS)-1:0] hit_way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid[w] && (lines[w*LINE_W +: LINE_W] == key);
  end

  assign hit = |eq;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) hit_way = $clog2(WAYS)'(w);
    end
  end
endmodule

// File: rtl/vb_victim_pick.sv
module vb_victim_pick import vb_pkg::*; #(
  parameter int WAYS = 8
) (
  input  logic [WAYS-1:0]         valid,
  input  logic [WAYS-1:0]         done,
  output logic [$clog2(WAYS)-1:0] way,
  output vb_kind_e                kind
);
  logic found;

  always_comb begin
    way   = '0;
    kind  = KIND_LIVE;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid[w]) begin
        way   = $clog2(WAYS)'(w);
        kind  = KIND_FREE;
        found = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && done[w]) begin
        way   = $clog2(WAYS)'(w);
        kind  = KIND_DONE;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vb_tag_ctrl.sv
module vb_tag_ctrl import vb_pkg::*; #(
  parameter int LINE_W   = 48,
  parameter int TXN_W    = 15,
  parameter int WAYS     = 8,
  parameter int ENTRIES  = 16,
  parameter int HANDLE_W = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    req_valid,
  output logic                                    req_ready,
  input  logic [LINE_W+6-1:0]                     req_paddr,
  input  logic [TXN_W-1:0]                        req_txn,
  input  logic [HANDLE_W-1:0]                     req_handle,
  output logic                                    rsp_valid,
  input  logic                                    rsp_ready,
  output logic                                    rsp_hit,
  output logic [$clog2(ENTRIES)+$clog2(WAYS)-1:0] rsp_slot,
  output logic [HANDLE_W-1:0]                     rsp_handle,
  output logic                                    rsp_wb,
  output logic                                    rsp_abort,
  output logic [LINE_W-1:0]                       rsp_victim_line,
  output logic [TXN_W-1:0]                        rsp_victim_txn,
  output logic [WAYS*TXN_W-1:0]                   cq_txn,
  input  logic [WAYS-1:0]                         cq_done,
  output logic                                    ev_inc_valid,
  output logic [TXN_W-1:0]                        ev_inc_txn,
  output logic                                    ev_dec_valid,
  output logic [TXN_W-1:0]                        ev_dec_txn
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int SLOT_W = IDX_W + WAY_W;

  vb_state_e             st_q;
  logic [LINE_W-1:0]     key_line_q;
  logic [TXN_W-1:0]      key_txn_q;
  logic [HANDLE_W-1:0]   key_handle_q;
  logic [IDX_W-1:0]      idx;
  logic [WAYS-1:0]       rd_valid;
  logic [WAYS*LINE_W-1:0] rd_line;
  logic [WAYS*TXN_W-1:0] rd_txn;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way, pick_way, sel_way;
  vb_kind_e              pick_kind;
  logic [TXN_W-1:0]      old_txn;
  logic [LINE_W-1:0]     old_line;
  logic                  displace, owner_change, look;

  assign idx       = key_line_q[IDX_W-1:0];
  assign look      = (st_q == ST_LOOK);
  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);

  vb_entry_store #(.LINE_W(LINE_W), .TXN_W(TXN_W), .WAYS(WAYS), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx),
    .rd_valid(rd_valid), .rd_line(rd_line), .rd_txn(rd_txn),
    .wr_en(look), .wr_idx(idx), .wr_way(sel_way),
    .wr_line(key_line_q), .wr_txn(key_txn_q)
  );

  vb_way_match #(.LINE_W(LINE_W), .WAYS(WAYS)) u_match (
    .valid(rd_valid), .lines(rd_line), .key(key_line_q),
    .hit(hit), .hit_way(hit_way)
  );

  vb_victim_pick #(.WAYS(WAYS)) u_pick (
    .valid(rd_valid), .done(cq_done), .way(pick_way), .kind(pick_kind)
  );

  assign cq_txn       = rd_txn;
  assign sel_way      = hit ? hit_way : pick_way;
  assign old_txn      = rd_txn[sel_way*TXN_W +: TXN_W];
  assign old_line     = rd_line[sel_way*LINE_W +: LINE_W];
  assign displace     = !hit && (pick_kind != KIND_FREE);
  assign owner_change = hit && (old_txn != key_txn_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) st_q <= ST_LOOK;
        ST_LOOK: st_q <= ST_RESP;
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid && req_ready) begin
      key_line_q   <= req_paddr[LINE_W+LINE_OFF-1:LINE_OFF];
      key_txn_q    <= req_txn;
      key_handle_q <= req_handle;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit         <= 1'b0;
      rsp_slot        <= '0;
      rsp_handle      <= '0;
      rsp_wb          <= 1'b0;
      rsp_abort       <= 1'b0;
      rsp_victim_line <= '0;
      rsp_victim_txn  <= '0;
      ev_inc_valid    <= 1'b0;
      ev_inc_txn      <= '0;
      ev_dec_valid    <= 1'b0;
      ev_dec_txn      <= '0;
    end else if (look) begin
      rsp_hit         <= hit;
      rsp_slot        <= SLOT_W'({idx, sel_way});
      rsp_handle      <= key_handle_q;
      rsp_wb          <= displace && (pick_kind == KIND_DONE);
      rsp_abort       <= displace && (pick_kind == KIND_LIVE);
      rsp_victim_line <= displace ? old_line : '0;
      rsp_victim_txn  <= displace ? old_txn : '0;
      ev_inc_valid    <= !hit || owner_change;
      ev_inc_txn      <= key_txn_q;
      ev_dec_valid    <= displace || owner_change;
      ev_dec_txn      <= old_txn;
    end else begin
      ev_inc_valid    <= 1'b0;
      ev_dec_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/vb_tag_ctrl_chk.sv
module vb_tag_ctrl_chk #(
  parameter int TXN_W  = 15,
  parameter int SLOT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [SLOT_W-1:0] rsp_slot,
  input logic              rsp_wb,
  input logic              rsp_abort,
  input logic [TXN_W-1:0]  rsp_victim_txn,
  input logic              ev_inc_valid,
  input logic              ev_dec_valid,
  input logic [TXN_W-1:0]  ev_dec_txn
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_slot) && $stable(rsp_hit)); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R7
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !rsp_valid ##1 rsp_valid); // R9
  AST_EVT_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inc_valid || ev_dec_valid) |-> $rose(rsp_valid)); // R9
  AST_WB_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_wb && rsp_abort)); // R10
  AST_DISPLACE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_wb || rsp_abort) |-> !rsp_hit); // R10
  AST_ABORT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort && $rose(rsp_valid) |-> ev_dec_valid && (ev_dec_txn == rsp_victim_txn)); // R6
endmodule

bind vb_tag_ctrl vb_tag_ctrl_chk #(.TXN_W(TXN_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_slot(rsp_slot), .rsp_wb(rsp_wb), .rsp_abort(rsp_abort),
  .rsp_victim_txn(rsp_victim_txn), .ev_inc_valid(ev_inc_valid),
  .ev_dec_valid(ev_dec_valid), .ev_dec_txn(ev_dec_txn)
);

// File: tb/vb_tag_ctrl_bench.sv
module vb_tag_ctrl_bench;
  localparam int LW = 48, TW = 15, NW = 8, NE = 16, HW = 8, SW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic            req_valid = 1'b0, rsp_ready = 1'b0;
  logic            req_ready, rsp_valid, rsp_hit, rsp_wb, rsp_abort;
  logic [LW+5:0]   req_paddr = '0;
  logic [TW-1:0]   req_txn = '0;
  logic [HW-1:0]   req_handle = '0, rsp_handle;
  logic [SW-1:0]   rsp_slot;
  logic [LW-1:0]   rsp_victim_line;
  logic [TW-1:0]   rsp_victim_txn, ev_inc_txn, ev_dec_txn;
  logic [NW*TW-1:0] cq_txn;
  logic [NW-1:0]   cq_done;
  logic            ev_inc_valid, ev_dec_valid;

  bit              cmap [16];
  bit              mv [NE][NW];
  logic [LW-1:0]   ml [NE][NW];
  logic [TW-1:0]   mt [NE][NW];
  int              n_chk = 0, n_bad = 0;

  for (genvar g = 0; g < NW; g++) begin : g_cq
    assign cq_done[g] = cmap[cq_txn[g*TW +: 4]];
  end

  vb_tag_ctrl u_vb_tag_ctrl (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [LW+5:0] pa, input logic [TW-1:0] tx, input int hold);
    logic [3:0]    idx = pa[9:6];
    logic [LW-1:0] ln  = pa[LW+5:6];
    logic [HW-1:0] hd  = HW'($urandom);
    bit e_hit = 0, found = 0;
    int w = 0, kind = 0;
    bit e_wb, e_ab, e_inc, e_dec;
    logic [LW-1:0] vln;
    logic [TW-1:0] vtx;
    logic [SW-1:0] slot0;
    for (int i = 0; i < NW; i++)
      if (!e_hit && mv[idx][i] && ml[idx][i] == ln) begin e_hit = 1; w = i; end
    if (!e_hit) begin
      for (int i = 0; i < NW; i++)
        if (!found && !mv[idx][i]) begin found = 1; w = i; kind = 0; end
      for (int i = 0; i < NW; i++)
        if (!found && cmap[mt[idx][i][3:0]]) begin found = 1; w = i; kind = 1; end
      if (!found) begin w = 0; kind = 2; end
    end
    e_wb  = !e_hit && kind == 1;
    e_ab  = !e_hit && kind == 2;
    vln   = ml[idx][w];
    vtx   = mt[idx][w];
    e_inc = !e_hit || (mt[idx][w] != tx);
    e_dec = e_hit ? (mt[idx][w] != tx) : (kind != 0);
    mv[idx][w] = 1; ml[idx][w] = ln; mt[idx][w] = tx;

    @(negedge clk);
    req_valid = 1; req_paddr = pa; req_txn = tx; req_handle = hd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 0, "R9", "rsp_valid in lookup cycle", rsp_valid, 0);
    chk(req_ready == 0, "R7", "req_ready while busy", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1, "R9", "rsp_valid", rsp_valid, 1);
    chk(rsp_hit == e_hit, "R3", "hit", rsp_hit, e_hit);
    chk(rsp_slot == SW'(idx * NW + w), "R2", "slot", rsp_slot, idx * NW + w);
    chk(rsp_handle == hd, "R7", "handle", rsp_handle, hd);
    chk(rsp_wb == e_wb, "R5", "wb", rsp_wb, e_wb);
    chk(rsp_abort == e_ab, "R6", "abort", rsp_abort, e_ab);
    chk(!(rsp_wb && rsp_hit) && !(rsp_abort && rsp_hit), "R10", "displace on hit",
        {rsp_wb, rsp_abort, rsp_hit}, 0);
    if (e_wb || e_ab) begin
      chk(rsp_victim_line == vln, "R5", "victim line", rsp_victim_line, vln);
      chk(rsp_victim_txn == vtx, "R6", "victim txn", rsp_victim_txn, vtx);
    end
    chk(ev_inc_valid == e_inc, "R4", "inc valid", ev_inc_valid, e_inc);
    if (e_inc) chk(ev_inc_txn == tx, "R4", "inc txn", ev_inc_txn, tx);
    chk(ev_dec_valid == e_dec, "R8", "dec valid", ev_dec_valid, e_dec);
    if (e_dec) chk(ev_dec_txn == vtx, "R8", "dec txn", ev_dec_txn, vtx);
    slot0 = rsp_slot;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid && rsp_slot == slot0 && !req_ready, "R7", "hold stable",
          {rsp_valid, req_ready, rsp_slot}, {1'b1, 1'b0, slot0});
      chk(!ev_inc_valid && !ev_dec_valid, "R9", "event beyond first cycle",
          {ev_inc_valid, ev_dec_valid}, 0);
    end
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R7", "release after handshake",
        {rsp_valid, req_ready}, 2'b01);
  endtask

  function automatic logic [LW+5:0] mk_pa(input int tag, input int ent, input int off);
    return ((LW+6)'(tag) << 10) | ((LW+6)'(ent) << 6) | (LW+6)'(off);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    for (int e = 0; e < NE; e++)
      for (int i = 0; i < NW; i++) begin mv[e][i] = 0; ml[e][i] = '0; mt[e][i] = '0; end
    for (int t = 0; t < 16; t++) cmap[t] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0, "R1", "reset handshake", {req_ready, rsp_valid}, 2'b10);
    chk(!ev_inc_valid && !ev_dec_valid, "R1", "reset events", {ev_inc_valid, ev_dec_valid}, 0);

    // R4 R1: fill entry 5, all fields start invalid so ways 0..7 in order
    for (int i = 0; i < NW; i++) run_req(mk_pa(100 + i, 5, i), TW'(i + 1), 0);
    // R3 R8: same-owner hit emits nothing
    run_req(mk_pa(103, 5, 9), TW'(4), 1);
    // R8: hit by another transaction
    run_req(mk_pa(102, 5, 0), TW'(9), 0);
    // R6: full, all live -> field 0 aborted
    run_req(mk_pa(200, 5, 0), TW'(10), 2);
    // R5: two committed owners, lowest one written back
    cmap[4] = 1; cmap[6] = 1;
    run_req(mk_pa(201, 5, 0), TW'(11), 0);
    for (int t = 0; t < 16; t++) cmap[t] = 0;

    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(3) == 0) cmap[$urandom_range(15)] ^= 1'b1;
      run_req(mk_pa($urandom_range(11), $urandom_range(3), $urandom_range(63)),
              TW'($urandom_range(15)), $urandom_range(2));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule